// File: doc/BRIEF.md
# Link Bring-up Sequencer with APB Master

This block takes one serial gigabit Ethernet lane from power-up to a receive-enabled state. It stays quiet until a user start input rises. It then holds the MAC and PCS in reset until the lane PLL reports lock, and releases both resets together. Next it waits for the PHY to signal that its init handshake has finished. Only then does it drive the APB bus. The block makes two transfers. The first writes the signal-ok bit in the PCS lane register, which opens the receive path. The second reads the same register back. After that the block raises a done flag and stays idle.

Every APB read that completes is logged as an address/data pair in a small capture memory. A write pointer selects the slot and wraps at the end of the memory. A debug index input picks one slot, and that slot's contents appear on two debug output ports. If PLL lock is lost at any point after start, the block puts the MAC and PCS back in reset, abandons any transfer in flight, and runs the whole sequence again once lock returns. Routing the APB bus to several slaves is done outside this block.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, both reset outputs are low, psel_o is low, done_o is low and every capture entry reads as zero. Until start_i is seen high in the idle state, nothing changes, whatever pll_locked_i and phy_init_done_i do. Once the sequence has left idle, start_i has no further effect.
- R2: After start, mac_rst_n_o and pcs_rst_n_o stay low while pll_locked_i is low. Both go high one cycle after the clock edge at which lock is first sampled high.
- R3: No APB transfer starts before phy_init_done_i has been sampled high while the resets are released. psel_o rises two cycles after that sampling edge.
- R4: The first transfer is a write with pwrite_o=1. Its address is SIG_OK_ADDR (default 0xC00404, inside the PCS lane-0 window 0xC00400 to 0xC0043F). Its write data has only bit SIG_OK_BIT (default 0) set.
- R5: Every transfer has one setup cycle (psel_o=1, penable_o=0) followed by an access phase (psel_o=1, penable_o=1). The access phase is held, with its address stable, until pready_i is sampled high.
- R6: The second transfer is a read of SIG_OK_ADDR. One cycle after that read completes, done_o goes high and stays high with no further APB activity until lock is lost or reset is applied.
- R7: At each completed read, the pair {paddr, prdata_i} is stored at the capture write pointer. The pointer then advances by one and wraps from CAP_DEPTH-1 (default 15) back to 0.
- R8: dbg_idx_i selects a capture entry combinationally. Its stored data appears on dbg_data_o and its stored address on dbg_addr_o in the same cycle.
- R9: When pll_locked_i is sampled low in any state other than idle, the next cycle has both resets low, psel_o low and done_o low, and the block waits for lock again. When lock returns, the full sequence runs again.
- R10: Outside a transfer (psel_o low), paddr_o, pwrite_o and pwdata_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | User start request |
| pll_locked_i | input | 1 | Lane PLL lock indication |
| phy_init_done_i | input | 1 | PHY power-up handshake complete |
| mac_rst_n_o | output | 1 | Active-low reset to the MAC |
| pcs_rst_n_o | output | 1 | Active-low reset to the PCS |
| psel_o | output | 1 | APB select |
| penable_o | output | 1 | APB enable (access phase) |
| pwrite_o | output | 1 | APB write direction |
| paddr_o | output | 24 | APB address |
| pwdata_o | output | 32 | APB write data |
| prdata_i | input | 32 | APB read data |
| pready_i | input | 1 | APB slave ready |
| done_o | output | 1 | Bring-up sequence finished |
| dbg_idx_i | input | 4 | Capture entry select |
| dbg_data_o | output | 32 | Captured read data of the selected entry |
| dbg_addr_o | output | 24 | Captured address of the selected entry |

## Verification
The bench holds lock and init-done high before start, to catch a design that begins without the start request. It delays lock and init separately, so a design that releases resets early or starts APB traffic before the PHY handshake is caught at once. A slave that stalls pready for several cycles shows up a design that leaves the access phase too soon or lets the address change during it. The bench drops lock repeatedly, including in the middle of a stalled transfer and after done. This exposes a design that captures an aborted read, fails to restart, or leaves done high. More than sixteen reruns, with the debug index sweeping all slots, catch a write pointer that does not wrap or misfiles an entry.

// File: rtl/link_bringup_pkg.sv
package link_bringup_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT_LOCK,
    PH_WAIT_INIT,
    PH_CMD_WR,
    PH_CMD_RD,
    PH_DONE
  } phase_e;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_SETUP,
    BUS_ACCESS
  } bus_e;
endpackage

// File: rtl/bringup_ctrl.sv
module bringup_ctrl
  import link_bringup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic locked_i,
  input  logic init_done_i,
  input  logic xfer_done_i,
  output logic periph_rst_n_o,
  output logic req_o,
  output logic req_write_o,
  output logic seq_done_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (phase_q != PH_IDLE && !locked_i) begin
      phase_d = PH_WAIT_LOCK;
    end else begin
      case (phase_q)
        PH_IDLE:      if (start_i)     phase_d = PH_WAIT_LOCK;
        PH_WAIT_LOCK:                  phase_d = PH_WAIT_INIT;
        PH_WAIT_INIT: if (init_done_i) phase_d = PH_CMD_WR;
        PH_CMD_WR:    if (xfer_done_i) phase_d = PH_CMD_RD;
        PH_CMD_RD:    if (xfer_done_i) phase_d = PH_DONE;
        PH_DONE:                       phase_d = PH_DONE;
        default:                       phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign periph_rst_n_o = (phase_q == PH_WAIT_INIT) || (phase_q == PH_CMD_WR) ||
                          (phase_q == PH_CMD_RD)    || (phase_q == PH_DONE);
  assign req_o          = (phase_q == PH_CMD_WR) || (phase_q == PH_CMD_RD);
  assign req_write_o    = (phase_q == PH_CMD_WR);
  assign seq_done_o     = (phase_q == PH_DONE);

  // R2 / R9: a low lock sample always leaves the peripherals in reset next cycle
  p_reset_on_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_i |=> !periph_rst_n_o);
  // R1: idle without start stays idle
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !start_i) |=> (phase_q == PH_IDLE));
  // R6: done is sticky while locked
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done_o && locked_i) |=> seq_done_o);
endmodule

// File: rtl/apb_xfer.sv
module apb_xfer
  import link_bringup_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              pready_i,
  input  logic [DATA_W-1:0] prdata_i,
  output logic              psel_o,
  output logic              penable_o,
  output logic              pwrite_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] pwdata_o,
  output logic              xfer_done_o,
  output logic              rd_capture_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  bus_e              bus_q, bus_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              launch;

  assign launch = (bus_q == BUS_IDLE) && req_i && !abort_i;

  always_comb begin
    bus_d = bus_q;
    if (abort_i) begin
      bus_d = BUS_IDLE;
    end else begin
      case (bus_q)
        BUS_IDLE:   if (launch)   bus_d = BUS_SETUP;
        BUS_SETUP:                bus_d = BUS_ACCESS;
        BUS_ACCESS: if (pready_i) bus_d = BUS_IDLE;
        default:                  bus_d = BUS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_q <= BUS_IDLE;
    else        bus_q <= bus_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (launch) begin
      wr_q    <= req_write_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  assign psel_o       = (bus_q != BUS_IDLE);
  assign penable_o    = (bus_q == BUS_ACCESS);
  assign pwrite_o     = psel_o && wr_q;
  assign paddr_o      = psel_o ? addr_q : '0;
  assign pwdata_o     = (psel_o && wr_q) ? wdata_q : '0;
  assign xfer_done_o  = (bus_q == BUS_ACCESS) && pready_i && !abort_i;
  assign rd_capture_o = xfer_done_o && !wr_q;
  assign rd_addr_o    = addr_q;
  assign rd_data_o    = prdata_i;

  // R5: setup is followed by access
  p_setup_to_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_o && !penable_o && !abort_i) |=> (psel_o && penable_o));
  // R5: access held with stable address while slave stalls
  p_access_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_o && penable_o && !pready_i && !abort_i) |=> (psel_o && penable_o && $stable(paddr_o)));
  // R10: quiet bus outside a transfer
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !psel_o |-> (paddr_o == '0 && !pwrite_o && pwdata_o == '0));
endmodule

// File: rtl/capture_ram.sv
module capture_ram #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IW-1:0]     idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [IW-1:0]     ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (we_i) ptr_d = (ptr_q == IW'(DEPTH - 1)) ? '0 : IW'(ptr_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_mem[g] <= '0;
        data_mem[g] <= '0;
      end else if (we_i && ptr_q == IW'(g)) begin
        addr_mem[g] <= waddr_i;
        data_mem[g] <= wdata_i;
      end
    end
  end

  assign addr_o = addr_mem[idx_i];
  assign data_o = data_mem[idx_i];

  // R7: pointer wraps to zero after the last slot
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && ptr_q == IW'(DEPTH - 1)) |=> (ptr_q == '0));
  // R7: pointer only moves on a capture
  p_ptr_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(ptr_q));
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int          ADDR_W      = 24,
  parameter int          DATA_W      = 32,
  parameter int          CAP_DEPTH   = 16,
  parameter int          SIG_OK_BIT  = 0,
  parameter logic [23:0] SIG_OK_ADDR = 24'hC00404,
  parameter logic [23:0] PCS_BASE    = 24'hC00400,
  parameter int          PCS_SPAN    = 64,
  localparam int         IDX_W       = $clog2(CAP_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pll_locked_i,
  input  logic              phy_init_done_i,
  output logic              mac_rst_n_o,
  output logic              pcs_rst_n_o,
  output logic              psel_o,
  output logic              penable_o,
  output logic              pwrite_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] pwdata_o,
  input  logic [DATA_W-1:0] prdata_i,
  input  logic              pready_i,
  output logic              done_o,
  input  logic [IDX_W-1:0]  dbg_idx_i,
  output logic [DATA_W-1:0] dbg_data_o,
  output logic [ADDR_W-1:0] dbg_addr_o
);
  localparam logic [DATA_W-1:0] SIG_OK_WDATA = DATA_W'(1) << SIG_OK_BIT;

  logic              periph_rst_n, req, req_write, xfer_done, rd_capture;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  bringup_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .locked_i       (pll_locked_i),
    .init_done_i    (phy_init_done_i),
    .xfer_done_i    (xfer_done),
    .periph_rst_n_o (periph_rst_n),
    .req_o          (req),
    .req_write_o    (req_write),
    .seq_done_o     (done_o)
  );

  apb_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_apb (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort_i      (!pll_locked_i),
    .req_i        (req),
    .req_write_i  (req_write),
    .req_addr_i   (ADDR_W'(SIG_OK_ADDR)),
    .req_wdata_i  (SIG_OK_WDATA),
    .pready_i     (pready_i),
    .prdata_i     (prdata_i),
    .psel_o       (psel_o),
    .penable_o    (penable_o),
    .pwrite_o     (pwrite_o),
    .paddr_o      (paddr_o),
    .pwdata_o     (pwdata_o),
    .xfer_done_o  (xfer_done),
    .rd_capture_o (rd_capture),
    .rd_addr_o    (rd_addr),
    .rd_data_o    (rd_data)
  );

  capture_ram #(.DEPTH(CAP_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (rd_capture),
    .waddr_i (rd_addr),
    .wdata_i (rd_data),
    .idx_i   (dbg_idx_i),
    .addr_o  (dbg_addr_o),
    .data_o  (dbg_data_o)
  );

  assign mac_rst_n_o = periph_rst_n;
  assign pcs_rst_n_o = periph_rst_n;

  // R3: no bus traffic while peripherals are in reset
  p_no_apb_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    psel_o |-> (mac_rst_n_o && pcs_rst_n_o));
  // R4: every access stays inside the PCS lane window
  p_addr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    psel_o |-> (paddr_o >= ADDR_W'(PCS_BASE) && paddr_o < ADDR_W'(PCS_BASE) + ADDR_W'(PCS_SPAN)));
  // R6: no traffic once finished
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !psel_o);
endmodule

// File: tb/link_bringup_seq_test.sv
module link_bringup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] ADDR = 24'hC00404;

  logic        clk, rst_n, start_i, pll_locked_i, phy_init_done_i, pready_i;
  logic [31:0] prdata_i;
  logic [3:0]  dbg_idx_i;
  logic        mac_rst_n_o, pcs_rst_n_o, psel_o, penable_o, pwrite_o, done_o;
  logic [23:0] paddr_o, dbg_addr_o;
  logic [31:0] pwdata_o, dbg_data_o;

  link_bringup_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pll_locked_i(pll_locked_i),
    .phy_init_done_i(phy_init_done_i), .mac_rst_n_o(mac_rst_n_o), .pcs_rst_n_o(pcs_rst_n_o),
    .psel_o(psel_o), .penable_o(penable_o), .pwrite_o(pwrite_o), .paddr_o(paddr_o),
    .pwdata_o(pwdata_o), .prdata_i(prdata_i), .pready_i(pready_i), .done_o(done_o),
    .dbg_idx_i(dbg_idx_i), .dbg_data_o(dbg_data_o), .dbg_addr_o(dbg_addr_o)
  );

  int checks = 0, failures = 0, cyc = 0, pmode = 0;
  bit finished = 0;

  // behavioural reference: phase 0 idle,1 wait lock,2 wait init,3 write,4 read,5 done
  int          m_ph, m_bus, m_wp;
  bit          m_wr;
  logic [31:0] m_d [16];
  logic [23:0] m_a [16];
  int          reads_seen = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ph = 0; m_bus = 0; m_wr = 0; m_wp = 0;
    for (int i = 0; i < 16; i++) begin m_d[i] = '0; m_a[i] = '0; end
  endtask

  task automatic model_step();
    bit comp;
    int nph, nbus;
    comp = (m_bus == 2) && pready_i && pll_locked_i;
    nbus = m_bus;
    if (!pll_locked_i) nbus = 0;
    else if (m_bus == 0 && (m_ph == 3 || m_ph == 4)) begin nbus = 1; m_wr = (m_ph == 3); end
    else if (m_bus == 1) nbus = 2;
    else if (m_bus == 2 && pready_i) nbus = 0;
    nph = m_ph;
    if (m_ph != 0 && !pll_locked_i) nph = 1;
    else case (m_ph)
      0: if (start_i) nph = 1;
      1: nph = 2;
      2: if (phy_init_done_i) nph = 3;
      3: if (comp) nph = 4;
      4: if (comp) nph = 5;
      default: nph = m_ph;
    endcase
    if (comp && !m_wr) begin
      m_d[m_wp] = prdata_i; m_a[m_wp] = ADDR;
      m_wp = (m_wp + 1) % 16; reads_seen++;
    end
    m_ph = nph; m_bus = nbus;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (!rst_n) model_reset(); else model_step();
    chk("R1 R2 R9 mac reset", 64'(mac_rst_n_o), 64'(m_ph >= 2));
    chk("R1 R2 R9 pcs reset", 64'(pcs_rst_n_o), 64'(m_ph >= 2));
    chk("R3 R5 psel", 64'(psel_o), 64'(m_bus != 0));
    chk("R5 penable", 64'(penable_o), 64'(m_bus == 2));
    chk("R4 R10 pwrite", 64'(pwrite_o), 64'(m_bus != 0 && m_wr));
    chk("R4 R10 paddr", 64'(paddr_o), 64'((m_bus != 0) ? ADDR : 24'h0));
    chk("R4 R10 pwdata", 64'(pwdata_o), 64'((m_bus != 0 && m_wr) ? 32'h1 : 32'h0));
    chk("R6 R9 done", 64'(done_o), 64'(m_ph == 5));
    chk("R7 R8 dbg data", 64'(dbg_data_o), 64'(m_d[dbg_idx_i]));
    chk("R7 R8 dbg addr", 64'(dbg_addr_o), 64'(m_a[dbg_idx_i]));
    pready_i  = (pmode == 0) ? 1'b1 : (cyc % 4 == 0);
    prdata_i  = 32'hA500_0000 + 32'(cyc);
    dbg_idx_i = 4'(cyc);
  endtask

  initial begin
    rst_n = 0; start_i = 0; pll_locked_i = 0; phy_init_done_i = 0;
    pready_i = 1; prdata_i = 0; dbg_idx_i = 0;
    model_reset();
    repeat (3) tick();
    rst_n = 1;
    // R1: lock and init high but no start
    pll_locked_i = 1; phy_init_done_i = 1;
    repeat (6) tick();
    // R2/R3: start, then delayed lock and init, stalling slave
    pll_locked_i = 0; phy_init_done_i = 0; start_i = 1;
    tick(); start_i = 0;
    repeat (4) tick();
    pll_locked_i = 1;
    repeat (3) tick();
    phy_init_done_i = 1; pmode = 1;
    repeat (20) tick();
    // R1: start after leaving idle is ignored
    start_i = 1; repeat (3) tick(); start_i = 0;
    // R7/R9: many relocks to wrap the capture pointer
    pmode = 0;
    for (int k = 0; k < 18; k++) begin
      pll_locked_i = 0; repeat (2) tick();
      pll_locked_i = 1; repeat (10) tick();
    end
    // R9: lock loss in the middle of a stalled transfer
    pmode = 1;
    pll_locked_i = 0; repeat (2) tick();
    pll_locked_i = 1; repeat (4) tick();
    pll_locked_i = 0; tick();
    pll_locked_i = 1; repeat (24) tick();
    // R7: pointer must have wrapped
    checks++;
    if (reads_seen <= 16) begin
      failures++;
      $display("FAIL R7 wrap not reached actual=%0d expected>16", reads_seen);
    end
    repeat (16) tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule